// File: doc/BRIEF.md
# Binary inner product through thermometer, one-hot and table encoding

The block takes two N-bit binary vectors, a coefficient vector and an input vector. It forms their inner product s, the number of positions where both vectors hold a one, so s lies between 0 and N. The count is not produced by an adder tree feeding the output. It passes through three registered stages. The first compares the match count against a ladder of thresholds, one per position, and yields a thermometer code. The second takes adjacent thermometer bits and yields a one-hot index. The third turns that index into the output word by reading an (N+1)-entry table.

After reset, the table holds each entry's own index, so the output is the binary value of s. Software may rewrite any entry through a small write port while no vector is in flight. This lets the last stage apply an activation function in place. One example is an 8-bit unsigned fixed-point sigmoid with scale 256, where index 3 maps to 0.953, stored as 0xF4. A new vector pair is accepted on every clock.

Top module: `binip_pipe`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, out_vld_o, out_data_o and err_o are all 0. Reset also returns every table entry k to the value k.
- R2: out_vld_o is in_vld_i delayed by exactly three clock edges, counting the edge that samples the input. A new pair may be presented every cycle, and each pair yields its own result.
- R3: With an unmodified table entry, a valid result carries s = number of bit positions set in both coef_i and vec_i. This covers s = 0 and s = N. The value is formed through a thermometer code whose bit j (j = 0..N) is 1 exactly when j <= s. A one-hot code follows it: bit j is thermometer bit j AND NOT bit j+1, and bit N is passed through unchanged.
- R4: When the one-hot code of a valid result has exactly one bit set, err_o stays 0. Otherwise err_o is 1 for that result and out_data_o is forced to 0. Legal inputs always give exactly one set bit.
- R5: A write with cfg_we_i = 1 replaces table entry cfg_addr_i (0..N) with cfg_data_i. The write is accepted only at an edge where in_vld_i is low and no earlier pair is still in the pipeline. Later results with s equal to that address carry the written word, for example 0xF4 at index 3.
- R6: A write presented while in_vld_i is high, or while a pair is in flight, leaves the table unchanged.
- R7: Whenever out_vld_o is 0, out_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Vector pair valid |
| coef_i | input | N | Binary coefficient vector |
| vec_i | input | N | Binary input vector |
| cfg_we_i | input | 1 | Table write enable |
| cfg_addr_i | input | $clog2(N+1) | Table entry index |
| cfg_data_i | input | OUT_W | Table entry value |
| out_vld_o | output | 1 | Result valid |
| out_data_o | output | OUT_W | Table word for the index s |
| err_o | output | 1 | One-hot code was not single-hot |

## Verification
The bench builds the block with N = 8 and OUT_W = 8. The 9-entry table then covers every index from 0 to 8. Each word is wide enough for an 8-bit sigmoid value, so the identity encoding and a reprogrammed activation entry can be checked in the same run. The address width is 4 with these values, which brings a full-scale count (s = N) and a zero count within the same small vectors. Random traffic mixes gaps and back-to-back pairs with write attempts. Many of those writes land while a pair is in flight.

// File: rtl/binip_pkg.sv
package binip_pkg;
  // bits needed to index 0..n inclusive
  function automatic int idx_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/binip_ladder.sv
module binip_ladder #(
  parameter int N  = 8,
  parameter int CW = binip_pkg::idx_w(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [N-1:0] coef_i,
  input  logic [N-1:0] vec_i,
  output logic         vld_o,
  output logic [N:0]   thermo_o
);
  logic [N-1:0] match;
  logic [CW-1:0] cnt;
  logic [N:0] thermo_d;

  assign match = coef_i & vec_i;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(match[i]);
  end

  // threshold ladder: column j fires once the count reaches j
  for (genvar j = 0; j <= N; j++) begin : g_col
    assign thermo_d[j] = (cnt >= CW'(j));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      thermo_o <= '0;
    end else begin
      vld_o    <= vld_i;
      thermo_o <= vld_i ? thermo_d : '0;
    end
  end
endmodule

// File: rtl/binip_edge.sv
module binip_edge #(
  parameter int N = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic [N:0] thermo_i,
  output logic       vld_o,
  output logic [N:0] hot_o
);
  logic [N:0] hot_d;

  // on a thermometer, xor of neighbours reduces to and-not
  for (genvar j = 0; j < N; j++) begin : g_pair
    assign hot_d[j] = thermo_i[j] & ~thermo_i[j+1];
  end
  assign hot_d[N] = thermo_i[N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      hot_o <= '0;
    end else begin
      vld_o <= vld_i;
      hot_o <= vld_i ? hot_d : '0;
    end
  end
endmodule

// File: rtl/binip_lut.sv
module binip_lut #(
  parameter int N     = 8,
  parameter int OUT_W = 8,
  parameter int CW    = binip_pkg::idx_w(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [N:0]       hot_i,
  input  logic             wr_en_i,
  input  logic [CW-1:0]    wr_addr_i,
  input  logic [OUT_W-1:0] wr_data_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] data_o,
  output logic             err_o
);
  logic [OUT_W-1:0] tbl [N+1];
  logic [OUT_W-1:0] sel;
  logic             bad;

  for (genvar k = 0; k <= N; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 tbl[k] <= OUT_W'(k);
      else if (wr_en_i && (wr_addr_i == CW'(k)))   tbl[k] <= wr_data_i;
    end
  end

  // and-or mux driven straight by the one-hot lines
  always_comb begin
    sel = '0;
    for (int k = 0; k <= N; k++) if (hot_i[k]) sel = sel | tbl[k];
  end

  assign bad = (hot_i == '0) || ((hot_i & (hot_i - 1'b1)) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      err_o  <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      data_o <= (vld_i && !bad) ? sel : '0;
      err_o  <= vld_i && bad;
    end
  end
endmodule

// File: rtl/binip_pipe.sv
module binip_pipe #(
  parameter int N     = 8,
  parameter int OUT_W = 8,
  localparam int CW   = binip_pkg::idx_w(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_vld_i,
  input  logic [N-1:0]     coef_i,
  input  logic [N-1:0]     vec_i,
  input  logic             cfg_we_i,
  input  logic [CW-1:0]    cfg_addr_i,
  input  logic [OUT_W-1:0] cfg_data_i,
  output logic             out_vld_o,
  output logic [OUT_W-1:0] out_data_o,
  output logic             err_o
);
  logic       s1_vld, s2_vld;
  logic [N:0] s1_thermo, s2_hot;
  logic       wr_ok;

  // table changes only with nothing in flight
  assign wr_ok = cfg_we_i & ~(in_vld_i | s1_vld | s2_vld);

  binip_ladder #(.N(N), .CW(CW)) u_ladder (
    .clk_i, .rst_ni, .vld_i(in_vld_i), .coef_i, .vec_i,
    .vld_o(s1_vld), .thermo_o(s1_thermo)
  );

  binip_edge #(.N(N)) u_edge (
    .clk_i, .rst_ni, .vld_i(s1_vld), .thermo_i(s1_thermo),
    .vld_o(s2_vld), .hot_o(s2_hot)
  );

  binip_lut #(.N(N), .OUT_W(OUT_W), .CW(CW)) u_lut (
    .clk_i, .rst_ni, .vld_i(s2_vld), .hot_i(s2_hot),
    .wr_en_i(wr_ok), .wr_addr_i(cfg_addr_i), .wr_data_i(cfg_data_i),
    .vld_o(out_vld_o), .data_o(out_data_o), .err_o
  );
endmodule

// File: rtl/binip_pipe_chk.sv
module binip_pipe_chk #(
  parameter int N     = 8,
  parameter int OUT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_vld_i,
  input logic             out_vld_o,
  input logic [OUT_W-1:0] out_data_o,
  input logic             err_o,
  input logic             s1_vld,
  input logic [N:0]       s1_thermo,
  input logic             s2_vld,
  input logic [N:0]       s2_hot
);
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o == $past(in_vld_i, 3));

  p_thermo_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld |-> (s1_thermo[0] && (((s1_thermo >> 1) & ~s1_thermo) == '0)));

  p_single_hot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld |-> ($countones(s2_hot) == 1));

  p_no_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> !err_o);

  p_quiet_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> (out_data_o == '0 && !err_o));
endmodule

bind binip_pipe binip_pipe_chk #(.N(N), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_vld_i(in_vld_i),
  .out_vld_o(out_vld_o), .out_data_o(out_data_o), .err_o(err_o),
  .s1_vld(s1_vld), .s1_thermo(s1_thermo), .s2_vld(s2_vld), .s2_hot(s2_hot)
);

// File: tb/binip_pipe_tb_top.sv
module binip_pipe_tb_top;
  localparam int N     = 8;
  localparam int OUT_W = 8;
  localparam int CW    = $clog2(N + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic [N-1:0]     coef = '0, vec = '0;
  logic             we = 1'b0;
  logic [CW-1:0]    addr = '0;
  logic [OUT_W-1:0] wdat = '0;
  logic             out_vld;
  logic [OUT_W-1:0] out_data;
  logic             err;

  binip_pipe #(.N(N), .OUT_W(OUT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .coef_i(coef), .vec_i(vec),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(wdat),
    .out_vld_o(out_vld), .out_data_o(out_data), .err_o(err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [OUT_W-1:0] tbl [N+1];
  bit               tblw [N+1];
  logic             hv_v [1:3];
  logic [OUT_W-1:0] hv_d [1:3];
  bit               hv_w [1:3];
  string            tag_force = "";

  function automatic int pc(logic [N-1:0] x);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(x[i]);
    return c;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k <= N; k++) begin tbl[k] = OUT_W'(k); tblw[k] = 0; end
    for (int k = 1; k <= 3; k++) begin hv_v[k] = 0; hv_d[k] = '0; hv_w[k] = 0; end
  endtask

  // called at a falling edge: check, update model, drive next inputs
  task automatic step(bit v, logic [N-1:0] a, logic [N-1:0] b,
                      bit w, int wa, logic [OUT_W-1:0] wd);
    string t;
    bit busy;
    int s;
    chk(out_vld == hv_v[3], "R2", "out_vld_o", int'(out_vld), int'(hv_v[3]));
    if (hv_v[3]) begin
      t = (tag_force != "") ? tag_force : (hv_w[3] ? "R5" : "R3");
      chk(out_data == hv_d[3], t, "out_data_o", int'(out_data), int'(hv_d[3]));
      chk(err == 1'b0, "R4", "err_o", int'(err), 0);
    end else begin
      chk(out_data == '0, "R7", "out_data_o idle", int'(out_data), 0);
    end
    busy = v | hv_v[1] | hv_v[2];
    if (w && !busy && wa <= N) begin tbl[wa] = wd; tblw[wa] = 1; end
    for (int k = 3; k > 1; k--) begin
      hv_v[k] = hv_v[k-1]; hv_d[k] = hv_d[k-1]; hv_w[k] = hv_w[k-1];
    end
    s = pc(a & b);
    hv_v[1] = v; hv_d[1] = tbl[s]; hv_w[1] = tblw[s];
    in_vld = v; coef = a; vec = b; we = w; addr = CW'(wa); wdat = wd;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, '0);
  endtask

  task automatic do_reset();
    in_vld = 0; we = 0; coef = '0; vec = '0;
    rst_n = 1'b0;
    clear_model();
    repeat (4) @(negedge clk);
    chk(out_vld == 0, "R1", "out_vld_o in reset", int'(out_vld), 0);
    chk(out_data == '0, "R1", "out_data_o in reset", int'(out_data), 0);
    chk(err == 0, "R1", "err_o in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 0 && out_data == '0 && err == 0, "R1", "outputs after release",
        int'(out_vld), 0);
  endtask

  function automatic logic [N-1:0] ones(int k);
    logic [N-1:0] r = '0;
    for (int i = 0; i < k; i++) r[i] = 1'b1;
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    // R3 corner counts, back to back (R2 throughput)
    tag_force = "R3";
    step(1, '0, '1, 0, 0, '0);
    step(1, '1, '1, 0, 0, '0);
    step(1, 8'b00101011, 8'b10111110, 0, 0, '0);
    step(1, ones(5), '1, 0, 0, '0);
    idle(3);

    // R5 sigmoid entry at index 3
    tag_force = "R5";
    step(0, '0, '0, 1, 3, 8'hF4);
    step(1, 8'b00101011, 8'b10111110, 0, 0, '0);
    step(1, ones(4), ones(7), 0, 0, '0);
    idle(3);

    // R6 writes attempted while busy
    tag_force = "R6";
    step(1, ones(2), '1, 1, 2, 8'h55);
    step(0, '0, '0, 1, 5, 8'h11);
    step(0, '0, '0, 1, 6, 8'h22);
    idle(3);
    step(1, ones(2), '1, 0, 0, '0);
    step(1, ones(5), '1, 0, 0, '0);
    step(1, '1, ones(6), 0, 0, '0);
    idle(3);

    // random mix
    tag_force = "";
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 10) < 7;
      bit w = ($urandom % 10) < 2;
      step(v, N'($urandom), N'($urandom), w, int'($urandom % (N + 1)), OUT_W'($urandom));
    end
    idle(3);

    // R1 reset restores identity table
    do_reset();
    tag_force = "R1";
    step(1, 8'b00101011, 8'b10111110, 0, 0, '0);
    step(1, '1, '1, 0, 0, '0);
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule